// File: doc/BRIEF.md
# Decimal Index Register and Loop Counter

This unit keeps a bank of decimal index registers and executes the loop-control operations that use them. Each register holds three fields, all binary-coded decimal: a three-digit pass count, a four-digit step and a five-digit address offset. A loop operation lowers the pass count by one and moves the offset up or down by the step. It then tests the lowered count and tells the sequencer whether to branch back to the loop head or to fall through to the next instruction.

The same bank supplies offsets for address indexing. For any operation, the selected register's offset is added in decimal to the address digits of the instruction. Register 00 means no indexing and contributes an offset of zero. Because the count is lowered before the test, loading a count of 000 makes the loop run one thousand times. An operation is presented for one cycle with `valid_i`. Its results appear registered on the next cycle with `done_o`, so operations can be issued back to back.

Top module: `ix_loop_unit`

## Requirements
- R1: `done_o` is high in the cycle after each cycle in which `valid_i` is high, and low in every other cycle. The results for that operation are on the outputs while `done_o` is high.
- R2: `reg_sel_i` holds two BCD digits, tens in [7:4] and units in [3:0], and selects registers 01 to 99. A selection of 00, a selection with a digit above 9, or a selection above the bank size reads as all-zero fields and ignores writes.
- R3: Op code 1 (load) writes `load_word_i` into the selected register. The count is in [47:36], the step in [35:20] and the offset in [19:0], all in BCD.
- R4: Op code 2 (count-up loop) stores count minus one (mod 1000) and offset plus step (mod 100000), both in decimal.
- R5: Op code 3 (count-down loop) stores count minus one (mod 1000) and offset minus step (mod 100000), both in decimal.
- R6: For op codes 2 and 3 the test uses the lowered count. If it is nonzero, `taken_o`=1 and `next_pc_o`=`target_i`. If it is zero, `taken_o`=0 and `next_pc_o`=`pc_i`+1 in decimal (mod 100000).
- R7: A loaded count of 000 wraps to 999 on the first loop operation, so exactly 1000 loop operations occur before the first fall-through.
- R8: For every operation, `index_addr_o` is `target_i` plus the selected register's offset as it stood before the operation, in decimal mod 100000.
- R9: Op codes 0 (no-op) and 4 (index) leave the bank unchanged and give `taken_o`=0 and `next_pc_o`=`pc_i`+1.
- R10: The asynchronous reset clears every register field to zero and holds `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Op code: 0 no-op, 1 load, 2 count-up loop, 3 count-down loop, 4 index |
| reg_sel_i | input | 8 | Two BCD digits selecting the index register |
| target_i | input | 20 | Five BCD address digits: branch target and base for indexing |
| pc_i | input | 20 | Current instruction counter, five BCD digits |
| load_word_i | input | 48 | Register image for load: count, step, offset |
| done_o | output | 1 | Results valid |
| taken_o | output | 1 | Loop branch taken |
| next_pc_o | output | 20 | Next instruction counter, BCD |
| index_addr_o | output | 20 | Indexed address, BCD |

## Verification
Loop operations are run on a short count with a small step, so that the taken passes and the single fall-through are separated. An offset near 99999 going up and a small offset going down show whether decimal wrap and borrow are handled, as opposed to binary wrap. A count of 000 run for a full thousand passes confirms the decrement-before-test rule, as opposed to an immediate exit. Selections of 00 and with a digit above 9, a counter of 99999, and no-op and index operations between reads show whether anything leaks into the bank or the branch decision.

// File: rtl/ix_loop_pkg.sv
package ix_loop_pkg;
  localparam int CNT_DIG = 3;
  localparam int INC_DIG = 4;
  localparam int MOD_DIG = 5;
  localparam int SEL_DIG = 2;
  localparam int CNT_W   = 4 * CNT_DIG;
  localparam int INC_W   = 4 * INC_DIG;
  localparam int MOD_W   = 4 * MOD_DIG;
  localparam int SEL_W   = 4 * SEL_DIG;
  localparam int IDX_W   = 7;
  localparam int WORD_W  = CNT_W + INC_W + MOD_W;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_UP    = 3'd2,
    OP_DN    = 3'd3,
    OP_INDEX = 3'd4
  } ix_op_e;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [INC_W-1:0] inc;
    logic [MOD_W-1:0] mdf;
  } ix_reg_t;

  function automatic logic all_bcd(input logic [MOD_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int d = 0; d < MOD_DIG; d++) if (v[4*d +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/ix_bcd_addsub.sv
module ix_bcd_addsub #(
  parameter int DIGITS = 5
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  logic                sub_i,
  output logic [4*DIGITS-1:0] sum_o
);
  // subtraction = add nines' complement plus one; top carry discarded (mod 10^DIGITS)
  logic [DIGITS-1:0] carry;
  assign carry[0] = sub_i;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    logic [3:0] b_dig;
    logic [4:0] raw;
    logic [4:0] adj;
    assign b_dig = sub_i ? (4'd9 - b_i[4*d +: 4]) : b_i[4*d +: 4];
    assign raw   = {1'b0, a_i[4*d +: 4]} + {1'b0, b_dig} + {4'd0, carry[d]};
    assign adj   = (raw > 5'd9) ? raw + 5'd6 : raw;
    assign sum_o[4*d +: 4] = adj[3:0];
    if (d < DIGITS - 1) begin : g_carry
      assign carry[d+1] = (raw > 5'd9);
    end
  end
endmodule

// File: rtl/ix_sel_decode.sv
module ix_sel_decode
  import ix_loop_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [3:0] tens, ones;
  assign tens = sel_i[7:4];
  assign ones = sel_i[3:0];

  always_comb begin
    if (tens > 4'd9 || ones > 4'd9) idx_o = '0;
    else idx_o = IDX_W'(tens) * IDX_W'(10) + IDX_W'(ones);
  end

  always_comb begin
    if (sel_i == '0) assert (idx_o == '0) else $error("AST_SEL_ZERO");  // R2
  end
endmodule

// File: rtl/ix_regfile.sv
module ix_regfile
  import ix_loop_pkg::*;
#(
  parameter int NUM_REGS = 99
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wr_en_i,
  input  ix_reg_t          wr_data_i,
  output ix_reg_t          rd_data_o
);
  ix_reg_t regs [1:NUM_REGS];
  logic    hit;

  assign hit       = (idx_i != '0) && (int'(idx_i) <= NUM_REGS);
  assign rd_data_o = hit ? regs[idx_i] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i <= NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en_i && hit) begin
      regs[idx_i] <= wr_data_i;
    end
  end

  AST_MISS_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> rd_data_o == '0);  // R2
endmodule

// File: rtl/ix_loop_unit.sv
module ix_loop_unit
  import ix_loop_pkg::*;
#(
  parameter int NUM_REGS = 99
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [MOD_W-1:0]  target_i,
  input  logic [MOD_W-1:0]  pc_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [MOD_W-1:0]  next_pc_o,
  output logic [MOD_W-1:0]  index_addr_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [MOD_W-1:0] PC_ONE  = MOD_W'(1);

  ix_op_e           op;
  logic [IDX_W-1:0] idx;
  ix_reg_t          cur, wr_data;
  logic             is_loop, wr_en, taken_d;
  logic [CNT_W-1:0] new_cnt;
  logic [MOD_W-1:0] new_mdf, pc_inc, idx_sum, next_pc_d;

  assign op = ix_op_e'(op_i);

  ix_sel_decode u_dec (.sel_i(reg_sel_i), .idx_o(idx));

  ix_regfile #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i, .rst_ni, .idx_i(idx), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(cur)
  );

  ix_bcd_addsub #(.DIGITS(CNT_DIG)) u_cnt_dec (
    .a_i(cur.cnt), .b_i(CNT_ONE), .sub_i(1'b1), .sum_o(new_cnt)
  );
  ix_bcd_addsub #(.DIGITS(MOD_DIG)) u_mdf_step (
    .a_i(cur.mdf), .b_i({4'd0, cur.inc}), .sub_i(op == OP_DN), .sum_o(new_mdf)
  );
  ix_bcd_addsub #(.DIGITS(MOD_DIG)) u_pc_inc (
    .a_i(pc_i), .b_i(PC_ONE), .sub_i(1'b0), .sum_o(pc_inc)
  );
  ix_bcd_addsub #(.DIGITS(MOD_DIG)) u_idx_add (
    .a_i(target_i), .b_i(cur.mdf), .sub_i(1'b0), .sum_o(idx_sum)
  );

  assign is_loop   = (op == OP_UP) || (op == OP_DN);
  assign wr_en     = valid_i && ((op == OP_LOAD) || is_loop);
  assign taken_d   = is_loop && (new_cnt != '0);
  assign next_pc_d = taken_d ? target_i : pc_inc;

  always_comb begin
    if (op == OP_LOAD) wr_data = ix_reg_t'(load_word_i);
    else begin
      wr_data     = cur;
      wr_data.cnt = new_cnt;
      wr_data.mdf = new_mdf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      taken_o      <= 1'b0;
      next_pc_o    <= '0;
      index_addr_o <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        taken_o      <= taken_d;
        next_pc_o    <= next_pc_d;
        index_addr_o <= idx_sum;
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);  // R1
  AST_TAKEN_TO_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_loop |=> (!taken_o || next_pc_o == $past(target_i)));  // R6
  AST_PLAIN_NO_BRANCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_NOP || op_i == OP_INDEX) |=> !taken_o);  // R9
  AST_SEL00_NO_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && reg_sel_i == '0 |=> index_addr_o == $past(target_i));  // R2
  AST_INDEX_IS_BCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> all_bcd(index_addr_o) && all_bcd(next_pc_o));  // R8
endmodule

// File: tb/ix_loop_unit_test.sv
`timescale 1ns/1ps
module ix_loop_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [7:0]  reg_sel_i = '0;
  logic [19:0] target_i = '0, pc_i = '0;
  logic [47:0] load_word_i = '0;
  logic        done_o, taken_o;
  logic [19:0] next_pc_o, index_addr_o;

  always #2.5 clk = ~clk;

  ix_loop_unit uut (
    .clk_i(clk), .rst_ni, .valid_i, .op_i, .reg_sel_i, .target_i, .pc_i, .load_word_i,
    .done_o, .taken_o, .next_pc_o, .index_addr_o
  );

  typedef struct {
    logic [19:0] pc;
    logic        taken;
    logic [19:0] idx;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  int m_cnt[100], m_inc[100], m_mdf[100];

  function automatic logic [19:0] to_bcd(input int v);
    logic [19:0] r;
    int t;
    t = v;
    for (int d = 0; d < 5; d++) begin r[4*d +: 4] = 4'(t % 10); t = t / 10; end
    return r;
  endfunction

  function automatic int from_bcd(input logic [19:0] b);
    int r;
    r = 0;
    for (int d = 4; d >= 0; d--) r = r * 10 + int'(b[4*d +: 4]);
    return r;
  endfunction

  function automatic int sel_to_idx(input logic [7:0] s);
    if (s[7:4] > 4'd9 || s[3:0] > 4'd9) return 0;
    return int'(s[7:4]) * 10 + int'(s[3:0]);
  endfunction

  function automatic logic [47:0] mk_word(input int c, input int i, input int m);
    logic [19:0] bc, bi, bm;
    bc = to_bcd(c); bi = to_bcd(i); bm = to_bcd(m);
    return {bc[11:0], bi[15:0], bm};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [19:0] act, input logic [19:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] sel, input int tgt,
                       input int pc, input logic [47:0] word, input string tag);
    exp_t e;
    int k, nc, nm;
    k = sel_to_idx(sel);
    e.idx   = to_bcd((tgt + m_mdf[k]) % 100000);
    e.taken = 1'b0;
    e.pc    = to_bcd((pc + 1) % 100000);
    e.tag   = tag;
    if (op == 3'd1 && k != 0) begin
      m_cnt[k] = from_bcd({8'd0, word[47:36]});
      m_inc[k] = from_bcd({4'd0, word[35:20]});
      m_mdf[k] = from_bcd(word[19:0]);
    end else if (op == 3'd2 || op == 3'd3) begin
      nc = (m_cnt[k] + 999) % 1000;
      nm = (op == 3'd2) ? (m_mdf[k] + m_inc[k]) % 100000
                        : (m_mdf[k] - m_inc[k] + 100000) % 100000;
      if (k != 0) begin m_cnt[k] = nc; m_mdf[k] = nm; end
      if (nc != 0) begin e.taken = 1'b1; e.pc = to_bcd(tgt); end
    end
    @(negedge clk);
    valid_i = 1'b1; op_i = op; reg_sel_i = sel;
    target_i = to_bcd(tgt); pc_i = to_bcd(pc); load_word_i = word;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); valid_i = 1'b0; end
  endtask

  // monitor: compare each result against the scoreboard
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_ni && done_o) begin
        if (sb.size() == 0) chk(1'b0, "R1", "unexpected done", 20'd1, 20'd0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(next_pc_o == e.pc, e.tag, "next_pc", next_pc_o, e.pc);
          chk(taken_o == e.taken, e.tag, "taken", {19'd0, taken_o}, {19'd0, e.taken});
          chk(index_addr_o == e.idx, e.tag, "index", index_addr_o, e.idx);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog", 20'd0, 20'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 100; i++) begin m_cnt[i] = 0; m_inc[i] = 0; m_mdf[i] = 0; end
    #1;
    chk(done_o == 1'b0, "R10", "done in reset", {19'd0, done_o}, 20'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    chk(done_o == 1'b0, "R1", "done while idle", {19'd0, done_o}, 20'd0);

    // R10: bank starts cleared
    issue(3'd4, 8'h05, 12345, 100, '0, "R10");
    // R3 / R8: load then index
    issue(3'd1, 8'h07, 50, 100, mk_word(3, 25, 100), "R3");
    issue(3'd4, 8'h07, 50, 101, '0, "R8");
    // R4 / R6: count-up loop, two taken then fall-through
    issue(3'd2, 8'h07, 150, 200, '0, "R4");
    issue(3'd2, 8'h07, 150, 200, '0, "R6");
    issue(3'd2, 8'h07, 150, 200, '0, "R6");
    issue(3'd4, 8'h07, 1, 300, '0, "R4");
    // R9: no-op and index leave bank alone
    issue(3'd0, 8'h07, 2, 301, mk_word(9, 9, 9), "R9");
    issue(3'd4, 8'h07, 2, 302, '0, "R9");
    issue(3'd4, 8'h07, 2, 303, '0, "R9");
    // R5: count-down with decimal borrow wrap
    issue(3'd1, 8'h12, 0, 400, mk_word(2, 25, 10), "R3");
    issue(3'd3, 8'h12, 777, 401, '0, "R5");
    issue(3'd4, 8'h12, 20, 402, '0, "R5");
    issue(3'd3, 8'h12, 777, 99999, '0, "R6");
    // R4: offset wrap upward
    issue(3'd1, 8'h33, 0, 500, mk_word(5, 20, 99990), "R3");
    issue(3'd2, 8'h33, 600, 501, '0, "R4");
    issue(3'd4, 8'h33, 99995, 502, '0, "R8");
    // R2: register 00 and a non-BCD selection
    issue(3'd1, 8'h00, 0, 600, mk_word(4, 4, 444), "R2");
    issue(3'd4, 8'h00, 4321, 601, '0, "R2");
    issue(3'd2, 8'h00, 888, 602, '0, "R2");
    issue(3'd1, 8'h1A, 0, 603, mk_word(4, 4, 444), "R2");
    issue(3'd4, 8'h1A, 4321, 604, '0, "R2");
    issue(3'd4, 8'h10, 4321, 605, '0, "R2");
    idle(2);
    chk(done_o == 1'b0, "R1", "done after burst", {19'd0, done_o}, 20'd0);
    // R7: count 000 gives one thousand passes
    issue(3'd1, 8'h99, 0, 700, mk_word(0, 1, 0), "R3");
    for (int p = 0; p < 1000; p++) issue(3'd2, 8'h99, 900, 950, '0, "R7");
    issue(3'd4, 8'h99, 0, 951, '0, "R7");
    idle(3);
    chk(sb.size() == 0, "R1", "pending results", 20'(sb.size()), 20'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule